// File: doc/BRIEF.md
# Center-Aligned Up/Down Period Counter

This block is the time base of a pulse-width modulator. It holds a counter whose period comes from an auto-reload value. It can count in two ways. In edge-aligned operation it counts up and wraps to zero. In center-aligned operation it climbs to the reload value and then descends back to zero. A 2-bit mode input chooses between these. The three non-zero codes also tell the downstream compare logic in which counting direction it may raise compare flags.

The reload value can be used directly, or it can be staged through a shadow register that loads only on an update event. An update event is issued at every wrap or turnaround, and also on a software update strobe. Hardware owns the direction bit while center-aligned operation is active. Software can still overwrite the counter. Such a write follows fixed rules: writing zero or the reload value sets the direction without an update event, and writing a value above the reload value leaves the direction alone.

Top module: `updn_center_timer`

## Requirements
- R1: After reset the count is 0, the direction output is 0 (up), the update-event output is 0 and the staged reload value is 0.
- R2: With mode 00 and run high, the count rises by one per cycle. In the cycle after the count equals (or exceeds) the effective reload value P, the count shows 0 and upd_evt is high. With run low the count holds.
- R3: With a non-zero mode and run high, the count climbs to P and then falls to 0, repeating. After the top, the count shows P-1, down_q shows 1 and upd_evt is high, all in the same cycle. After the bottom, the count shows 1, down_q shows 0 and upd_evt is high.
- R4: cmp_allow is 1 in mode 00 and mode 11. In mode 01 it equals down_q (flags only while counting down). In mode 10 it equals the inverse of down_q (flags only while counting up).
- R5: A direction write (dir_wr with dir_wdata) takes effect in the next cycle only in mode 00, and it does not change edge-aligned counting, which always goes up. In any non-zero mode the write is ignored.
- R6: On entering a center-aligned mode, counting proceeds in the direction that down_q already holds.
- R7: In a center-aligned mode, a counter write of a value greater than P loads the count, keeps down_q unchanged and raises no upd_evt. Counting then continues in the same direction.
- R8: In a center-aligned mode, a counter write of 0 sets down_q to 0, and a write of P sets down_q to 1. Neither write raises upd_evt.
- R9: With pre_en high, the reload value in use changes only at an update event. With pre_en low, a new reload_val is used from the next cycle.
- R10: sw_upd has priority over a counter write. It clears the count to 0, raises upd_evt in the next cycle and loads the staged reload value. In a center-aligned mode it also sets down_q to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter enable |
| mode | input | 2 | 00 edge-aligned; 01/10/11 center-aligned with the flag direction per R4 |
| reload_val | input | W | Auto-reload (preload) value |
| pre_en | input | 1 | Stage reload_val through the shadow register |
| dir_wr | input | 1 | Software direction write strobe |
| dir_wdata | input | 1 | Direction to write (1 = down) |
| sw_upd | input | 1 | Software update-generate strobe |
| cnt_wr | input | 1 | Software counter write strobe |
| cnt_wdata | input | W | Counter write value |
| cnt_q | output | W | Current count |
| down_q | output | 1 | Current direction (1 = down) |
| upd_evt | output | 1 | One-cycle update-event pulse |
| cmp_allow | output | 1 | Compare flags may be set in the current direction |

## Verification
Every registered result appears exactly one cycle after the edge that samples its stimulus. This covers a count step, a wrap or turnaround together with its update pulse and direction flip, a counter or direction write, a software update, and a shadow load. cmp_allow is combinational from mode and the registered direction, so it follows a mode change in the same cycle. The bench drives inputs just after a falling edge and reads results at the next falling edge, half a period after the rising edge that produced them. Its arithmetic model of the count, direction and update pulse is a function of the number of cycles since the last software update.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;

  typedef enum logic [1:0] {
    CM_EDGE     = 2'b00,
    CM_FLAG_DN  = 2'b01,
    CM_FLAG_UP  = 2'b10,
    CM_FLAG_ALL = 2'b11
  } cnt_mode_e;

  // Whether compare logic may set flags in the given direction.
  function automatic logic flag_window(input logic [1:0] m, input logic down);
    case (m)
      CM_FLAG_DN: flag_window = down;
      CM_FLAG_UP: flag_window = ~down;
      default:    flag_window = 1'b1;
    endcase
  endfunction

  function automatic logic is_center(input logic [1:0] m);
    is_center = (m != CM_EDGE);
  endfunction

endpackage

// File: rtl/updn_period_shadow.sv
module updn_period_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pre_en,
  input  logic [W-1:0] reload_val,
  input  logic         load_evt,
  output logic [W-1:0] eff_per
);

  logic [W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shadow_q <= '0;
    else if (load_evt) shadow_q <= reload_val;
  end

  assign eff_per = pre_en ? shadow_q : reload_val;

  // R9: the staged value moves only on an update event
  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(shadow_q));

  assert_shadow_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> shadow_q == $past(reload_val));

endmodule

// File: rtl/updn_dir_reg.sv
module updn_dir_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic center,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic hw_set,
  input  logic hw_val,
  output logic dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dir_q <= 1'b0;
    else if (hw_set)           dir_q <= hw_val;
    else if (sw_wr && !center) dir_q <= sw_val;
  end

  // R5: software cannot move the direction in center-aligned modes
  assert_dir_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (center && !hw_set) |=> $stable(dir_q));

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         center,
  input  logic [W-1:0] eff_per,
  input  logic         sw_upd,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         dir_q,
  output logic [W-1:0] cnt_q,
  output logic         upd_q,
  output logic         dir_set,
  output logic         dir_val,
  output logic         evt
);

  typedef struct packed {
    logic [W-1:0] cnt;
    logic         turn;
    logic         dir;
  } step_t;

  localparam logic [W-1:0] ONE = W'(1);

  function automatic step_t edge_step(input logic [W-1:0] c, input logic [W-1:0] p,
                                      input logic d);
    step_t r;
    r.dir = d;
    if (c >= p) begin
      r.cnt  = '0;
      r.turn = 1'b1;
    end else begin
      r.cnt  = c + ONE;
      r.turn = 1'b0;
    end
    return r;
  endfunction

  function automatic step_t center_step(input logic [W-1:0] c, input logic [W-1:0] p,
                                        input logic d);
    step_t r;
    r.dir  = d;
    r.turn = 1'b0;
    r.cnt  = c;
    if (!d) begin
      if (c == p) begin
        r.turn = 1'b1;
        r.dir  = 1'b1;
        r.cnt  = (p == '0) ? '0 : p - ONE;
      end else begin
        r.cnt = c + ONE;
      end
    end else begin
      if (c == '0) begin
        r.turn = 1'b1;
        r.dir  = 1'b0;
        r.cnt  = (p == '0) ? '0 : ONE;
      end else begin
        r.cnt = c - ONE;
      end
    end
    return r;
  endfunction

  step_t        nxt;
  logic [W-1:0] cnt_d;
  logic         turn;

  always_comb begin
    nxt     = center ? center_step(cnt_q, eff_per, dir_q)
                     : edge_step(cnt_q, eff_per, dir_q);
    cnt_d   = cnt_q;
    turn    = 1'b0;
    dir_set = 1'b0;
    dir_val = dir_q;
    if (sw_upd) begin
      cnt_d = '0;
      if (center) begin
        dir_set = 1'b1;
        dir_val = 1'b0;
      end
    end else if (cnt_wr) begin
      cnt_d = cnt_wdata;
      if (center && cnt_wdata == '0) begin
        dir_set = 1'b1;
        dir_val = 1'b0;
      end else if (center && cnt_wdata == eff_per) begin
        dir_set = 1'b1;
        dir_val = 1'b1;
      end
    end else if (run) begin
      cnt_d = nxt.cnt;
      turn  = nxt.turn;
      if (center) begin
        dir_set = nxt.turn;
        dir_val = nxt.dir;
      end
    end
  end

  assign evt = sw_upd | turn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      upd_q <= evt;
    end
  end

  // R2: edge-aligned wrap lands on zero with an update pulse
  assert_edge_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !center && !sw_upd && !cnt_wr && cnt_q >= eff_per) |=> (cnt_q == '0 && upd_q));

  // R2: a stopped counter holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sw_upd && !cnt_wr) |=> ($stable(cnt_q) && !upd_q));

  // R10: software update clears the count and pulses the update output
  assert_sw_upd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_upd |=> (cnt_q == '0 && upd_q));

endmodule

// File: rtl/updn_center_timer.sv
module updn_center_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [1:0]   mode,
  input  logic [W-1:0] reload_val,
  input  logic         pre_en,
  input  logic         dir_wr,
  input  logic         dir_wdata,
  input  logic         sw_upd,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  output logic [W-1:0] cnt_q,
  output logic         down_q,
  output logic         upd_evt,
  output logic         cmp_allow
);

  import updn_tmr_pkg::*;

  logic         center;
  logic [W-1:0] eff_per;
  logic         evt;
  logic         hw_dir_set;
  logic         hw_dir_val;

  assign center = is_center(mode);

  updn_period_shadow #(.W(W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .pre_en     (pre_en),
    .reload_val (reload_val),
    .load_evt   (evt),
    .eff_per    (eff_per)
  );

  updn_count_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .center    (center),
    .eff_per   (eff_per),
    .sw_upd    (sw_upd),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .dir_q     (down_q),
    .cnt_q     (cnt_q),
    .upd_q     (upd_evt),
    .dir_set   (hw_dir_set),
    .dir_val   (hw_dir_val),
    .evt       (evt)
  );

  updn_dir_reg u_dir (
    .clk    (clk),
    .rst_n  (rst_n),
    .center (center),
    .sw_wr  (dir_wr),
    .sw_val (dir_wdata),
    .hw_set (hw_dir_set),
    .hw_val (hw_dir_val),
    .dir_q  (down_q)
  );

  assign cmp_allow = flag_window(mode, down_q);

  // R8: counter writes never raise an update event
  assert_wr_no_upd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !sw_upd) |=> !upd_evt);

  // R7: a write above the period leaves the direction alone
  assert_wr_above_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (center && cnt_wr && !sw_upd && cnt_wdata > eff_per) |=> $stable(down_q));

  // R3: top turnaround flips to down with an update pulse
  assert_top_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (center && run && !sw_upd && !cnt_wr && !down_q && cnt_q == eff_per)
      |=> (down_q && upd_evt));

  // R3: bottom turnaround flips to up with an update pulse
  assert_bot_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (center && run && !sw_upd && !cnt_wr && down_q && cnt_q == '0)
      |=> (!down_q && upd_evt));

endmodule

// File: tb/updn_center_timer_bench.sv
module updn_center_timer_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] reload_val = '0;
  logic         pre_en = 1'b0;
  logic         dir_wr = 1'b0;
  logic         dir_wdata = 1'b0;
  logic         sw_upd = 1'b0;
  logic         cnt_wr = 1'b0;
  logic [W-1:0] cnt_wdata = '0;
  logic [W-1:0] cnt_q;
  logic         down_q;
  logic         upd_evt;
  logic         cmp_allow;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  updn_center_timer #(.W(W)) u_updn_center_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .reload_val(reload_val),
    .pre_en(pre_en), .dir_wr(dir_wr), .dir_wdata(dir_wdata), .sw_upd(sw_upd),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .down_q(down_q),
    .upd_evt(upd_evt), .cmp_allow(cmp_allow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int allow_of(input int m, input int dn);
    if (m == 1) return dn;
    if (m == 2) return 1 - dn;
    return 1;
  endfunction

  // Sweep one mode and period after a software update; expected values from phase arithmetic
  task automatic sweep(input int m, input int p);
    mode = m[1:0];
    reload_val = p[W-1:0];
    pre_en = 1'b1;
    run = 1'b0;
    dir_wr = 1'b1;
    dir_wdata = 1'b0;
    @(negedge clk);
    dir_wr = 1'b0;
    sw_upd = 1'b1;
    run = 1'b1;
    for (int k = 0; k <= 4 * p + 3; k++) begin
      int ec, ed, eu, ph;
      @(negedge clk);
      sw_upd = 1'b0;
      if (m == 0) begin
        ec = k % (p + 1);
        ed = 0;
        eu = (ec == 0) ? 1 : 0;
        chk("R2 edge count", cnt_q, ec);
        chk("R2 edge update", upd_evt, eu);
      end else begin
        ph = k % (2 * p);
        ec = (ph <= p) ? ph : 2 * p - ph;
        ed = (k > 0 && (ph > p || ph == 0)) ? 1 : 0;
        eu = (k == 0 || ph == (p + 1) % (2 * p) || (ph == 1 && k > 1)) ? 1 : 0;
        chk("R3 center count", cnt_q, ec);
        chk("R3 center update", upd_evt, eu);
      end
      chk("R3 direction", down_q, ed);
      chk("R4 cmp_allow", cmp_allow, allow_of(m, ed));
    end
    run = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", cnt_q, 0);
    chk("R1 dir", down_q, 0);
    chk("R1 upd", upd_evt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pre_en = 1'b1;
    @(negedge clk);
    chk("R1 staged reload zero", cnt_q, 0);
    run = 1'b1;
    @(negedge clk);
    chk("R1 zero period wrap upd", upd_evt, 1);
    run = 1'b0;
    @(negedge clk);

    for (int m = 0; m < 4; m++)
      for (int p = 1; p <= 6; p++)
        sweep(m, p);

    // R5 direction write accepted in edge mode, counting still up
    mode = 2'b00; pre_en = 1'b0; reload_val = 8'd5;
    dir_wr = 1'b1; dir_wdata = 1'b1;
    @(negedge clk);
    dir_wr = 1'b0;
    chk("R5 edge dir write", down_q, 1);
    sw_upd = 1'b1; run = 1'b1;
    @(negedge clk);
    sw_upd = 1'b0;
    chk("R10 sw_upd count", cnt_q, 0);
    @(negedge clk);
    chk("R5 edge counts up", cnt_q, 1);
    run = 1'b0;
    mode = 2'b01; dir_wr = 1'b1; dir_wdata = 1'b0;
    @(negedge clk);
    dir_wr = 1'b0;
    chk("R5 center dir write ignored", down_q, 1);
    chk("R2 hold when stopped", cnt_q, 1);
    // R6 entry keeps the held direction (down)
    run = 1'b1;
    @(negedge clk);
    chk("R6 count down", cnt_q, 0);
    chk("R6 dir", down_q, 1);
    chk("R6 upd", upd_evt, 0);
    @(negedge clk);
    chk("R3 bottom turn count", cnt_q, 1);
    chk("R3 bottom turn dir", down_q, 0);
    chk("R3 bottom turn upd", upd_evt, 1);
    chk("R4 mode01 up", cmp_allow, 0);
    run = 1'b0;

    // R7 write above period
    cnt_wr = 1'b1; cnt_wdata = 8'd9;
    @(negedge clk);
    cnt_wr = 1'b0;
    chk("R7 count", cnt_q, 9);
    chk("R7 dir up kept", down_q, 0);
    chk("R7 no upd", upd_evt, 0);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    chk("R7 continues up", cnt_q, 10);
    cnt_wr = 1'b1; cnt_wdata = 8'd5;
    @(negedge clk);
    chk("R8 write P dir", down_q, 1);
    chk("R8 write P no upd", upd_evt, 0);
    cnt_wdata = 8'd9;
    @(negedge clk);
    cnt_wr = 1'b0;
    chk("R7 dir down kept", down_q, 1);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    chk("R7 continues down", cnt_q, 8);
    cnt_wr = 1'b1; cnt_wdata = 8'd0;
    @(negedge clk);
    cnt_wr = 1'b0;
    chk("R8 write 0 dir", down_q, 0);
    chk("R8 write 0 no upd", upd_evt, 0);

    // R9 preload enabled: new value waits for the next update event
    mode = 2'b00; pre_en = 1'b1; reload_val = 8'd3;
    sw_upd = 1'b1; run = 1'b1;
    @(negedge clk);
    sw_upd = 1'b0;
    reload_val = 8'd6;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk("R9 old period", cnt_q, i);
    end
    @(negedge clk);
    chk("R9 wrap at staged value", cnt_q, 0);
    chk("R9 wrap upd", upd_evt, 1);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R9 new period", cnt_q, i);
    end
    @(negedge clk);
    chk("R9 wrap at new value", cnt_q, 0);
    // R9 preload disabled: immediate use
    pre_en = 1'b0;
    @(negedge clk);
    chk("R9 direct count", cnt_q, 1);
    reload_val = 8'd2;
    @(negedge clk);
    chk("R9 direct count 2", cnt_q, 2);
    @(negedge clk);
    chk("R9 direct wrap", cnt_q, 0);
    chk("R9 direct wrap upd", upd_evt, 1);
    run = 1'b0;

    // R10 software update beats a counter write, sets up in center mode
    mode = 2'b10; pre_en = 1'b1; reload_val = 8'd4;
    cnt_wr = 1'b1; cnt_wdata = 8'd2;
    @(negedge clk);
    cnt_wdata = 8'd2;
    dir_wr = 1'b0;
    cnt_wr = 1'b0;
    sw_upd = 1'b1;
    @(negedge clk);
    reload_val = 8'd4;
    cnt_wr = 1'b1; cnt_wdata = 8'd4;
    sw_upd = 1'b0;
    @(negedge clk);
    cnt_wr = 1'b0;
    chk("R8 down before update", down_q, 1);
    chk("R4 mode10 down", cmp_allow, 0);
    sw_upd = 1'b1; cnt_wr = 1'b1; cnt_wdata = 8'd3; reload_val = 8'd7;
    @(negedge clk);
    sw_upd = 1'b0; cnt_wr = 1'b0; run = 1'b1;
    chk("R10 count", cnt_q, 0);
    chk("R10 upd", upd_evt, 1);
    chk("R10 dir up", down_q, 0);
    chk("R4 mode10 up", cmp_allow, 1);
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      chk("R10 staged period", cnt_q, i);
    end
    @(negedge clk);
    run = 1'b0;
    chk("R3 top turn count", cnt_q, 6);
    chk("R3 top turn dir", down_q, 1);
    chk("R3 top turn upd", upd_evt, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule